// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that were hoisted above earlier stores. When such a load commits, an entry is written holding the destination register number, the start byte address and the access size. The load itself still goes to memory in the normal way, and this table only adds the tracking. Every store presents its byte range on a snoop port. Any tracked entry whose byte range shares at least one byte with the store is dropped.

At the load's original place in program order, a check names the destination register. If a live entry for that register exists, the hoisted load is confirmed. If the entry is missing or was dropped, the failure is reported so that recovery code can run. The table is keyed by register, so a second hoisted load to the same register replaces the first one. When every slot is live, slots are recycled in rotating order. A synchronous clear empties the table.

Top module: `spec_ld_table`

## Requirements
- R1: An insert (`ins_vld_i`) writes a live entry for `ins_reg_i` covering `ins_addr_i` and its size. A check for that register in any later cycle reports success until the entry is dropped.
- R2: A store (`st_vld_i`) drops every live entry whose range [a, a+sa) overlaps the store range [b, b+sb), meaning a < b+sb and b < a+sa. Entries that do not overlap are left untouched.
- R3: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Ranges are compared as unsigned values one bit wider than the address, so a range that runs past the top address does not wrap around to address 0.
- R4: The result of a check appears on `chk_ok_o`/`chk_fail_o` in the cycle after `chk_vld_i`. Exactly one of the two is high in that cycle, and both are low after a cycle with no check.
- R5: A check for a register with no live entry reports failure (`chk_fail_o`). This includes every register after reset.
- R6: An insert for a register that already has a live entry overwrites that entry. From then on, only the new range is snooped.
- R7: When an insert finds no live entry for its register and a free slot exists, it takes the free slot with the lowest index and evicts nothing.
- R8: When all 16 slots are live, an insert for a new register evicts the slot selected by a rotating pointer. The pointer starts at slot 0 after reset or clear and advances by one, wrapping, only on such an eviction.
- R9: When a store and an insert occur in the same cycle, the store is applied first. The new entry survives even if it overlaps the store.
- R10: `clr_i` drops every entry and returns the pointer to slot 0. It takes precedence over an insert or store in the same cycle.
- R11: A check looks at the table as it stood at the start of its cycle. An insert, store or clear in the same cycle does not affect that check's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all entries |
| ins_vld_i | input | 1 | Hoisted-load commit strobe |
| ins_reg_i | input | 7 | Destination register of the hoisted load |
| ins_addr_i | input | 32 | Start byte address of the hoisted load |
| ins_sz_i | input | 2 | Size code of the hoisted load |
| st_vld_i | input | 1 | Store snoop strobe |
| st_addr_i | input | 32 | Store start byte address |
| st_sz_i | input | 2 | Store size code |
| chk_vld_i | input | 1 | Check strobe |
| chk_reg_i | input | 7 | Register being checked |
| chk_ok_o | output | 1 | Check found a live entry (one cycle after the strobe) |
| chk_fail_o | output | 1 | Check found no live entry (one cycle after the strobe) |

## Verification
Inserts, stores and clears take effect at the clock edge that samples them. A check is therefore first affected by them when it is issued in the following cycle, and the check result is registered at the edge that samples the check. The bench drives every operation just after a falling edge and reads the check outputs at the next falling edge, which is exactly one cycle after the strobe. The overlap sweep combines 16 insert offsets, 16 store offsets and all four sizes of each access, and the expected hit for each case is computed from the interval arithmetic. Directed sequences then exercise same-cycle operations, the rotating eviction and the high end of the address space.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

    localparam int SLT_ENTRIES = 16;
    localparam int SLT_REG_W   = 7;
    localparam int SLT_ADDR_W  = 32;
    localparam int SLT_SZ_W    = 2;
    localparam int SLT_IDX_W   = $clog2(SLT_ENTRIES);

    typedef struct packed {
        logic                  valid;
        logic [SLT_REG_W-1:0]  rreg;
        logic [SLT_ADDR_W-1:0] addr;
        logic [SLT_SZ_W-1:0]   sz;
    } slt_entry_t;

    typedef struct packed {
        slt_entry_t [SLT_ENTRIES-1:0] ent;
        logic [SLT_IDX_W-1:0]         rr;
        logic                         ok;
        logic                         fail;
    } slt_state_t;

endpackage

// File: rtl/spec_ld_overlap.sv
module spec_ld_overlap #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 2
) (
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic [SZ_W-1:0]   a_sz_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    input  logic [SZ_W-1:0]   b_sz_i,
    output logic              hit_o
);
    // One extra bit so that a range ending past the top address does not wrap.
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo  = {1'b0, a_addr_i};
        b_lo  = {1'b0, b_addr_i};
        a_hi  = a_lo + (EXT_W'(1) << a_sz_i);
        b_hi  = b_lo + (EXT_W'(1) << b_sz_i);
        hit_o = (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/spec_ld_victim.sv
module spec_ld_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     same_i,
    input  logic [N-1:0]     free_i,
    input  logic [IDX_W-1:0] rr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             evict_o
);
    // Priority: same register, then lowest free slot, then rotating pointer.
    always_comb begin
        idx_o = rr_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) idx_o = IDX_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (same_i[i]) idx_o = IDX_W'(i);
        end
        evict_o = ~(|same_i) & ~(|free_i);
    end
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
    import spec_ld_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  ins_vld_i,
    input  logic [SLT_REG_W-1:0]  ins_reg_i,
    input  logic [SLT_ADDR_W-1:0] ins_addr_i,
    input  logic [SLT_SZ_W-1:0]   ins_sz_i,
    input  logic                  st_vld_i,
    input  logic [SLT_ADDR_W-1:0] st_addr_i,
    input  logic [SLT_SZ_W-1:0]   st_sz_i,
    input  logic                  chk_vld_i,
    input  logic [SLT_REG_W-1:0]  chk_reg_i,
    output logic                  chk_ok_o,
    output logic                  chk_fail_o
);
    localparam int N     = SLT_ENTRIES;
    localparam int IDX_W = SLT_IDX_W;

    slt_state_t st_q, st_d;

    logic [N-1:0]     ov;     // store overlaps entry
    logic [N-1:0]     surv;   // entry live after store
    logic [N-1:0]     same;   // surviving entry holds insert register
    logic [N-1:0]     lk;     // check lookup match on current table
    logic [IDX_W-1:0] vic_idx;
    logic             vic_evict;

    for (genvar g = 0; g < N; g++) begin : g_ent
        spec_ld_overlap #(
            .ADDR_W (SLT_ADDR_W),
            .SZ_W   (SLT_SZ_W)
        ) i_ovl (
            .a_addr_i (st_q.ent[g].addr),
            .a_sz_i   (st_q.ent[g].sz),
            .b_addr_i (st_addr_i),
            .b_sz_i   (st_sz_i),
            .hit_o    (ov[g])
        );
        assign surv[g] = st_q.ent[g].valid & ~(st_vld_i & ov[g]);
        assign same[g] = surv[g] & (st_q.ent[g].rreg == ins_reg_i);
        assign lk[g]   = st_q.ent[g].valid & (st_q.ent[g].rreg == chk_reg_i);
    end

    spec_ld_victim #(
        .N     (N),
        .IDX_W (IDX_W)
    ) i_victim (
        .same_i  (same),
        .free_i  (~surv),
        .rr_i    (st_q.rr),
        .idx_o   (vic_idx),
        .evict_o (vic_evict)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ok   = chk_vld_i & (|lk);
        st_d.fail = chk_vld_i & ~(|lk);
        for (int i = 0; i < N; i++) begin
            st_d.ent[i].valid = surv[i];
        end
        if (ins_vld_i) begin
            st_d.ent[vic_idx].valid = 1'b1;
            st_d.ent[vic_idx].rreg  = ins_reg_i;
            st_d.ent[vic_idx].addr  = ins_addr_i;
            st_d.ent[vic_idx].sz    = ins_sz_i;
            if (vic_evict) begin
                st_d.rr = (st_q.rr == IDX_W'(N - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
        if (clr_i) begin
            for (int i = 0; i < N; i++) begin
                st_d.ent[i].valid = 1'b0;
            end
            st_d.rr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chk_ok_o   = st_q.ok;
    assign chk_fail_o = st_q.fail;
endmodule

// File: rtl/spec_ld_table_chk.sv
module spec_ld_table_chk
    import spec_ld_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_i,
    input logic                 ins_vld_i,
    input logic [SLT_REG_W-1:0] ins_reg_i,
    input logic                 chk_vld_i,
    input logic [SLT_REG_W-1:0] chk_reg_i,
    input logic                 chk_ok_o,
    input logic                 chk_fail_o
);
    // R4
    ok_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chk_ok_o, chk_fail_o}));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld_i |=> (!chk_ok_o && !chk_fail_o));

    // R4
    chk_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld_i |=> (chk_ok_o || chk_fail_o));

    // R1
    ins_then_chk_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ins_vld_i && !clr_i) && chk_vld_i && chk_reg_i == $past(ins_reg_i))
        |=> chk_ok_o);

    // R10
    clr_then_chk_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && chk_vld_i) |=> chk_fail_o);
endmodule

bind spec_ld_table spec_ld_table_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .ins_vld_i  (ins_vld_i),
    .ins_reg_i  (ins_reg_i),
    .chk_vld_i  (chk_vld_i),
    .chk_reg_i  (chk_reg_i),
    .chk_ok_o   (chk_ok_o),
    .chk_fail_o (chk_fail_o)
);

// File: tb/test_spec_ld_table.sv
module test_spec_ld_table;
    import spec_ld_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  clr_i = 1'b0;
    logic                  ins_vld_i = 1'b0;
    logic [SLT_REG_W-1:0]  ins_reg_i = '0;
    logic [SLT_ADDR_W-1:0] ins_addr_i = '0;
    logic [SLT_SZ_W-1:0]   ins_sz_i = '0;
    logic                  st_vld_i = 1'b0;
    logic [SLT_ADDR_W-1:0] st_addr_i = '0;
    logic [SLT_SZ_W-1:0]   st_sz_i = '0;
    logic                  chk_vld_i = 1'b0;
    logic [SLT_REG_W-1:0]  chk_reg_i = '0;
    logic                  chk_ok_o, chk_fail_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    spec_ld_table i_spec_ld_table (.*);

    task automatic idle_inputs();
        clr_i = 0; ins_vld_i = 0; st_vld_i = 0; chk_vld_i = 0;
    endtask

    // One clock of stimulus, driven after a falling edge, ending at the next falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_ins(input int r, input longint a, input int sz);
        ins_vld_i = 1; ins_reg_i = SLT_REG_W'(r); ins_addr_i = SLT_ADDR_W'(a); ins_sz_i = SLT_SZ_W'(sz);
    endtask

    task automatic set_st(input longint a, input int sz);
        st_vld_i = 1; st_addr_i = SLT_ADDR_W'(a); st_sz_i = SLT_SZ_W'(sz);
    endtask

    task automatic set_chk(input int r);
        chk_vld_i = 1; chk_reg_i = SLT_REG_W'(r);
    endtask

    task automatic expect_res(input logic e_ok, input logic e_fail, input string tag);
        checks++;
        if (chk_ok_o !== e_ok || chk_fail_o !== e_fail) begin
            errors++;
            $display("FAIL %s: ok/fail actual %b%b expected %b%b", tag, chk_ok_o, chk_fail_o, e_ok, e_fail);
        end
    endtask

    task automatic do_chk(input int r, input logic exp_ok, input string tag);
        set_chk(r);
        cyc();
        expect_res(exp_ok, !exp_ok, tag);
    endtask

    task automatic do_ins(input int r, input longint a, input int sz);
        set_ins(r, a, sz); cyc();
    endtask

    task automatic do_st(input longint a, input int sz);
        set_st(a, sz); cyc();
    endtask

    task automatic do_clr();
        clr_i = 1; cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R5 reset state, R4 quiet outputs
        expect_res(0, 0, "R4 idle after reset");
        do_chk(3, 0, "R5 empty after reset");
        cyc();
        expect_res(0, 0, "R4 quiet after no-check cycle");

        // R2 R3 exhaustive overlap sweep
        for (int ao = 0; ao < 16; ao++)
            for (int as_ = 0; as_ < 4; as_++)
                for (int so = 0; so < 16; so++)
                    for (int ss = 0; ss < 4; ss++) begin
                        longint a = 64'h100 + ao;
                        longint b = 64'h100 + so;
                        longint sa = 64'd1 << as_;
                        longint sb = 64'd1 << ss;
                        logic ovl = (a < b + sb) && (b < a + sa);
                        do_clr();
                        do_ins(9, a, as_);
                        do_st(b, ss);
                        do_chk(9, !ovl, "R2 overlap sweep");
                    end

        // R1 insert then check, other register misses
        do_clr();
        do_ins(40, 64'h2000, 2);
        do_chk(40, 1, "R1 inserted entry hits");
        do_chk(41, 0, "R5 other register misses");

        // R3 no wrap at top of address space
        do_clr();
        do_ins(12, 64'hFFFF_FFFC, 3);
        do_st(64'h0, 3);
        do_chk(12, 1, "R3 store at 0 does not hit wrapped range");
        do_st(64'hFFFF_FFFF, 0);
        do_chk(12, 0, "R3 store at top byte hits");

        // R6 overwrite same register
        do_clr();
        do_ins(5, 64'h3000, 3);
        do_ins(5, 64'h4000, 3);
        do_st(64'h3000, 3);
        do_chk(5, 1, "R6 old range no longer snooped");
        do_st(64'h4004, 0);
        do_chk(5, 0, "R6 new range snooped");

        // R9 store and insert in one cycle
        do_clr();
        set_ins(7, 64'h5000, 2); set_st(64'h5000, 3); cyc();
        do_chk(7, 1, "R9 new entry survives same-cycle store");

        // R11 check sees table before same-cycle update
        do_clr();
        set_ins(30, 64'h6000, 0); set_chk(30); cyc();
        expect_res(0, 1, "R11 same-cycle insert invisible");
        do_chk(30, 1, "R1 visible next cycle");
        clr_i = 1; set_chk(30); cyc();
        expect_res(1, 0, "R11 same-cycle clear invisible");
        do_chk(30, 0, "R10 cleared");

        // R10 clear beats same-cycle insert
        clr_i = 1; set_ins(31, 64'h7000, 0); cyc();
        do_chk(31, 0, "R10 clear wins over insert");

        // R8 round-robin eviction after fill
        do_clr();
        for (int i = 0; i < 16; i++) do_ins(i, 64'h1000 + 16 * i, 3);
        for (int i = 0; i < 16; i++) do_chk(i, 1, "R7 all sixteen live");
        do_ins(20, 64'h8000, 3);
        do_chk(0, 0, "R8 slot 0 evicted first");
        do_chk(1, 1, "R8 slot 1 kept");
        do_chk(20, 1, "R8 new entry live");
        do_ins(21, 64'h8100, 3);
        do_chk(1, 0, "R8 slot 1 evicted second");
        do_chk(2, 1, "R8 slot 2 kept");

        // R7 freed slot taken without moving pointer
        do_st(64'h1000 + 16 * 7, 0);
        do_chk(7, 0, "R2 store drops reg 7");
        do_ins(22, 64'h8200, 3);
        do_chk(2, 1, "R7 free slot used, slot 2 kept");
        do_chk(22, 1, "R7 new entry live");
        do_ins(23, 64'h8300, 3);
        do_chk(2, 0, "R8 pointer resumes at slot 2");
        do_chk(3, 1, "R8 slot 3 kept");

        // R10 pointer reset by clear
        do_clr();
        for (int i = 0; i < 16; i++) do_ins(50 + i, 64'h9000 + 16 * i, 3);
        do_ins(70, 64'hA000, 3);
        do_chk(50, 0, "R10 pointer back at slot 0");
        do_chk(51, 1, "R10 slot 1 kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule